// File: doc/BRIEF.md
# Pipeline Data-Hazard Unit

This block holds the data-hazard logic of a five-stage in-order integer pipeline. It has two functions. The first is operand bypass. It compares the two source register indices of the instruction in the execute stage against the destination indices and write enables of the two older instructions in flight. For each ALU operand it returns a 2-bit select, which tells the operand multiplexers whether to take the register-file value or a newer result still in the pipeline.

The second function is the load-use interlock. A load in the execute stage has no data until the memory stage. If the instruction behind it in decode reads that load's destination, bypass cannot cover the gap. In that case the unit holds the program counter and the fetch/decode register for one cycle. It also raises a bubble select that clears the control bundle entering the decode/execute register.

The unit is purely combinational. Its outputs settle within the same cycle from the stage fields that the surrounding pipeline registers present.

Top module: `hazard_unit`

## Requirements
- R1: When the older stage (execute/memory boundary) has its write enable set and its destination equals an execute-stage source, that operand's select is 2'b10.
- R2: When only the oldest stage (memory/write-back boundary) has its write enable set with a matching destination, that operand's select is 2'b01.
- R3: When both stages match the same source, the select is 2'b10 (the newer result wins).
- R4: A destination index of 0 never produces a non-zero select, even with its write enable set.
- R5: With no qualifying match the select is 2'b00; a matching destination whose write enable is low does not count.
- R6: When `ex_load` is 1, `ex_rd` is non-zero and equals `id_rs1` or `id_rs2`, `pc_we` is 0.
- R7: Under the same condition as R6, `ifid_we` is 0.
- R8: Under the same condition as R6, `bubble` is 1 and every bit of `ctrl_out` is 0.
- R9: Without that condition, `pc_we` and `ifid_we` are 1, `bubble` is 0 and `ctrl_out` equals `ctrl_in`.
- R10: A load whose destination is 0, or a non-load whose destination matches a decode source, causes no stall.
- R11: Bypass selection and the stall are independent: both can be active in the same cycle, and each takes the value it would have alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | First source index of the execute-stage instruction |
| ex_rs2 | input | 5 | Second source index of the execute-stage instruction |
| mem_rd | input | 5 | Destination index at the execute/memory boundary |
| mem_we | input | 1 | Register write enable at the execute/memory boundary |
| wb_rd | input | 5 | Destination index at the memory/write-back boundary |
| wb_we | input | 1 | Register write enable at the memory/write-back boundary |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_rd | input | 5 | Destination index of the execute-stage instruction |
| id_rs1 | input | 5 | First source index of the decode-stage instruction |
| id_rs2 | input | 5 | Second source index of the decode-stage instruction |
| ctrl_in | input | 8 | Decoded control bundle headed for the decode/execute register |
| fwd_a | output | 2 | Bypass select for ALU operand A |
| fwd_b | output | 2 | Bypass select for ALU operand B |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble | output | 1 | High when the control bundle is being cleared |
| ctrl_out | output | 8 | Control bundle after bubble gating |

## Verification
Bypass selection and the load-use stall can be active in the same cycle. This happens when the execute-stage load's own sources match older destinations while its destination feeds a decode source. The bench builds this overlap with directed vectors, and it reaches it often in a long random run that draws indices from a small range (0 to 3). Each cycle it compares all six outputs against a behavioural model that it evaluates separately for each function. A stall must leave both selects unchanged, and a bypass must leave the stall outputs unchanged.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    typedef enum logic [1:0] {
        BYP_RF  = 2'b00,
        BYP_WB  = 2'b01,
        BYP_MEM = 2'b10
    } byp_e;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
    } stall_t;
endpackage

// File: rtl/byp_sel.sv
module byp_sel
    import hzd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_we,
    output byp_e          sel
);
    logic mem_hit_d;
    logic wb_hit_d;

    always_comb begin
        mem_hit_d = mem_we && (mem_rd != '0) && (mem_rd == src);
        wb_hit_d  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
        if (mem_hit_d)      sel = BYP_MEM;
        else if (wb_hit_d)  sel = BYP_WB;
        else                sel = BYP_RF;
    end

    always_comb begin
        a_r4_zero_src_no_bypass: assert (src != '0 || sel == BYP_RF)
            else $error("r4 select from x0");
        a_r5_idle_no_bypass: assert (mem_we || wb_we || sel == BYP_RF)
            else $error("r5 select without write enable");
        a_r3_legal_code: assert (sel != 2'b11)
            else $error("r3 illegal select");
    end
endmodule

// File: rtl/load_use_det.sv
module load_use_det #(
    parameter int RW   = 5,
    parameter int NSRC = 2
) (
    input  logic                     ex_load,
    input  logic [RW-1:0]            ex_rd,
    input  logic [NSRC-1:0][RW-1:0]  id_src,
    output logic                     hit
);
    logic [NSRC-1:0] match_d;

    for (genvar i = 0; i < NSRC; i++) begin : g_cmp
        assign match_d[i] = (id_src[i] == ex_rd);
    end

    always_comb begin
        hit = ex_load && (ex_rd != '0) && (|match_d);
    end

    always_comb begin
        a_r10_nonload_no_stall: assert (ex_load || !hit)
            else $error("r10 stall without load");
        a_r10_zero_dest_no_stall: assert (ex_rd != '0 || !hit)
            else $error("r10 stall on x0");
    end
endmodule

// File: rtl/ctrl_gate.sv
module ctrl_gate #(
    parameter int CW = 8
) (
    input  logic          bubble,
    input  logic [CW-1:0] ctrl_in,
    output logic [CW-1:0] ctrl_out
);
    for (genvar i = 0; i < CW; i++) begin : g_bit
        assign ctrl_out[i] = ctrl_in[i] & ~bubble;
    end

    always_comb begin
        a_r8_bubble_clears: assert (!bubble || ctrl_out == '0)
            else $error("r8 bubble left control bits");
        a_r9_pass_through: assert (bubble || ctrl_out == ctrl_in)
            else $error("r9 control altered");
    end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hzd_pkg::*;
#(
    parameter int RW = 5,
    parameter int CW = 8
) (
    input  logic [RW-1:0] ex_rs1,
    input  logic [RW-1:0] ex_rs2,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_we,
    input  logic          ex_load,
    input  logic [RW-1:0] ex_rd,
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic [CW-1:0] ctrl_in,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          pc_we,
    output logic          ifid_we,
    output logic          bubble,
    output logic [CW-1:0] ctrl_out
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][RW-1:0] ex_src;
    logic [NSRC-1:0][RW-1:0] id_src;
    byp_e [NSRC-1:0]         sel_d;
    logic                    lu_hit;
    stall_t                  stall_d;

    assign ex_src = {ex_rs2, ex_rs1};
    assign id_src = {id_rs2, id_rs1};

    for (genvar s = 0; s < NSRC; s++) begin : g_byp
        byp_sel #(.RW(RW)) u_sel (
            .src    (ex_src[s]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (sel_d[s])
        );
    end

    load_use_det #(.RW(RW), .NSRC(NSRC)) u_lu (
        .ex_load (ex_load),
        .ex_rd   (ex_rd),
        .id_src  (id_src),
        .hit     (lu_hit)
    );

    always_comb begin
        stall_d.pc_we   = !lu_hit;
        stall_d.ifid_we = !lu_hit;
        stall_d.bubble  = lu_hit;
    end

    ctrl_gate #(.CW(CW)) u_gate (
        .bubble   (stall_d.bubble),
        .ctrl_in  (ctrl_in),
        .ctrl_out (ctrl_out)
    );

    assign fwd_a   = sel_d[0];
    assign fwd_b   = sel_d[1];
    assign pc_we   = stall_d.pc_we;
    assign ifid_we = stall_d.ifid_we;
    assign bubble  = stall_d.bubble;

    always_comb begin
        a_r7_freeze_together: assert (pc_we == ifid_we)
            else $error("r7 freeze enables disagree");
        a_r6_bubble_with_freeze: assert (bubble == !pc_we)
            else $error("r6 bubble without freeze");
    end
endmodule

// File: tb/hazard_unit_test.sv
module hazard_unit_test;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic [4:0] ex_rs1, ex_rs2, mem_rd, wb_rd, ex_rd, id_rs1, id_rs2;
    logic       mem_we, wb_we, ex_load;
    logic [7:0] ctrl_in, ctrl_out;
    logic [1:0] fwd_a, fwd_b;
    logic       pc_we, ifid_we, bubble;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    hazard_unit uut (
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .mem_rd(mem_rd), .mem_we(mem_we),
        .wb_rd(wb_rd), .wb_we(wb_we), .ex_load(ex_load), .ex_rd(ex_rd),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ctrl_in(ctrl_in),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we), .ifid_we(ifid_we),
        .bubble(bubble), .ctrl_out(ctrl_out)
    );

    function automatic int model_sel(int src);
        bit m = mem_we && mem_rd != 0 && mem_rd == src;
        bit w = wb_we && wb_rd != 0 && wb_rd == src;
        if (m) return 2;
        if (w) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(int src);
        bit m = mem_we && mem_rd == src;
        bit w = wb_we && wb_rd == src;
        if (src == 0 && (m || w)) return "R4";
        if (m && w) return "R3";
        if (m) return "R1";
        if (w) return "R2";
        return "R5";
    endfunction

    function automatic bit model_stall();
        return ex_load && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit st = model_stall();
        string stag = st ? "R6" : ((ex_load || ex_rd != 0) ? "R10" : "R9");
        check(sel_tag(ex_rs1), fwd_a, model_sel(ex_rs1));
        check(sel_tag(ex_rs2), fwd_b, model_sel(ex_rs2));
        check(stag, pc_we, !st);
        check(st ? "R7" : stag, ifid_we, !st);
        check(st ? "R8" : "R9", bubble, st);
        check(st ? "R8" : "R9", ctrl_out, st ? 0 : ctrl_in);
    endtask

    task automatic apply(int a1, int a2, int mr, int mw, int wr, int ww,
                         int ld, int er, int i1, int i2, int c);
        @(posedge clk);
        ex_rs1 = 5'(a1); ex_rs2 = 5'(a2); mem_rd = 5'(mr); mem_we = 1'(mw);
        wb_rd = 5'(wr); wb_we = 1'(ww); ex_load = 1'(ld); ex_rd = 5'(er);
        id_rs1 = 5'(i1); id_rs2 = 5'(i2); ctrl_in = 8'(c);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // idle state: all zero, no bypass, no stall (R5, R9)
        apply(0,0,0,0,0,0,0,0,0,0,8'hA5);
        // R1: newer stage match on operand A
        apply(3,4,3,1,0,0,0,0,0,0,8'h11);
        // R2: older stage match on operand B
        apply(3,4,0,0,4,1,0,0,0,0,8'h22);
        // R3: both match, newer wins
        apply(7,7,7,1,7,1,0,0,0,0,8'h33);
        // R4: destination x0 with enables high
        apply(0,0,0,1,0,1,0,0,0,0,8'h44);
        // R5: matching destination, enables low
        apply(9,9,9,0,9,0,0,0,0,0,8'h55);
        // R6 R7 R8: load destination used by decode rs2
        apply(1,2,0,0,0,0,1,6,5,6,8'hFF);
        // R10: load to x0, non-load with match
        apply(1,2,0,0,0,0,1,0,0,0,8'h66);
        apply(1,2,0,0,0,0,0,6,6,6,8'h77);
        // R11: stall and bypass in the same cycle
        apply(12,13,12,1,13,1,1,20,20,1,8'hC3);
        apply(12,12,12,1,12,1,1,20,3,20,8'h3C);
        for (int n = 0; n < 3000; n++) begin
            apply($urandom_range(3), $urandom_range(3), $urandom_range(3),
                  $urandom_range(1), $urandom_range(3), $urandom_range(1),
                  $urandom_range(1), $urandom_range(3), $urandom_range(3),
                  $urandom_range(3), $urandom_range(255));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule